// File: doc/BRIEF.md
# Processor Status Byte with Interrupt Entry Sequencer

This block holds the 8-bit processor status byte of a small accumulator machine and decides when an external interrupt is taken. The byte packs carry, overflow, two sense-input mirrors, an interrupt-enable bit and three general-purpose flags. The three general flags leave the block as output pins so that software can signal external logic without a separate port.

The interrupt sequencer watches the synchronized sense-A input. At an instruction boundary, with interrupts enabled, it fires a one-cycle take pulse that tells the pointer file to swap the program counter with pointer 3. On the same edge it clears the enable bit, so a second interrupt cannot nest until software enables interrupts again. No return state is pushed anywhere. The swap is the whole entry.

Top module: `status_irq_unit`

## Requirements
- R1: After a clock edge with `rst_n` low, `status_o` is 0x00, `flag_o` is 0 and `irq_take_o` is 0.
- R2: `status_o` bit 7 is carry, bit 6 is overflow, bit 5 mirrors sense B, bit 4 mirrors sense A, bit 3 is interrupt enable, and bits 2:0 are the user flags.
- R3: Status bits 5 and 4 show the sense B and sense A pins as they were two clock edges earlier (two-flop synchronizer).
- R4: `flag_o` always equals status bits 2:0.
- R5: `ie_clr_i` clears the enable bit and `ie_set_i` sets it on the next edge. When both are high, clear wins.
- R6: `acc_we_i` loads status bits 7, 6, 3 and 2:0 from `acc_data_i` at the same positions. Bits 5:4 of `acc_data_i` have no effect.
- R7: `cy_we_i` and `ov_we_i` load bit 7 from `cy_i` and bit 6 from `ov_i`, and take priority over an accumulator write to those bits in the same cycle.
- R8: The enable and disable commands take priority over an accumulator write to bit 3 in the same cycle.
- R9: On an edge where `boundary_i` is high, the synchronized sense A is 1 and the enable bit is 1, `irq_take_o` goes high for the next cycle and the enable bit becomes 0. This clear overrides `ie_set_i` and any accumulator write in that cycle.
- R10: No take happens on an edge where `boundary_i` is low, whatever sense A shows.
- R11: No take happens while the enable bit is 0. This includes the boundary right after a take while sense A stays high.
- R12: `irq_take_o` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sense_a_i | input | 1 | Asynchronous sense A pin (interrupt request) |
| sense_b_i | input | 1 | Asynchronous sense B pin |
| cy_we_i | input | 1 | Carry update strobe |
| cy_i | input | 1 | New carry value |
| ov_we_i | input | 1 | Overflow update strobe |
| ov_i | input | 1 | New overflow value |
| ie_set_i | input | 1 | Enable-interrupt command |
| ie_clr_i | input | 1 | Disable-interrupt command |
| acc_we_i | input | 1 | Copy accumulator into status byte |
| acc_data_i | input | 8 | Accumulator value for the copy |
| boundary_i | input | 1 | Instruction-boundary strobe |
| flag_o | output | 3 | User flag pins |
| status_o | output | 8 | Status byte |
| irq_take_o | output | 1 | One-cycle request to swap PC with pointer 3 |

## Verification
The bench goes after the collisions: an interrupt take in the same cycle as an enable command or an accumulator write, clear against set, and carry updates against accumulator copies. A design with the wrong priority would come out of interrupt entry with interrupts still enabled, and would then fire a second take on the next boundary. Sense A is held high across several non-boundary cycles and across the boundary right after a take. A checker that is not gated by the strobe, or that does not clear the enable bit, shows up as an extra or a repeated pulse. Accumulator writes with bits 5:4 set test that the mirrors cannot be overwritten. Sense edges test that they appear exactly two edges late.

// File: rtl/status_irq_pkg.sv
// Package: shared widths, bit positions and the status byte layout.
// Assumes an 8-bit status byte with three user flags in the low bits.
package status_irq_pkg;
    localparam int STAT_W  = 8;
    localparam int FLAG_W  = 3;
    localparam int SYNC_N  = 2;

    localparam int BIT_CY  = 7;
    localparam int BIT_OV  = 6;
    localparam int BIT_SB  = 5;
    localparam int BIT_SA  = 4;
    localparam int BIT_IE  = 3;

    typedef struct packed {
        logic              cy;
        logic              ov;
        logic              sb;
        logic              sa;
        logic              ie;
        logic [FLAG_W-1:0] f;
    } status_t;
endpackage

// File: rtl/sense_sync.sv
// Module: multi-stage synchronizer for asynchronous sense pins.
// Assumes STAGES >= 2; output lags input by STAGES clock edges; reset clears all stages.
module sense_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    // Shift the pins through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) begin
                pipe_q[i] <= pipe_q[i-1];
            end
        end
    end

    assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/irq_entry.sv
// Module: interrupt-entry sequencer.
// Assumes sense A is already synchronized. Samples only at the boundary strobe,
// asks for the enable bit to be cleared on the deciding edge, and emits a
// registered one-cycle take pulse on the following cycle.
module irq_entry (
    input  logic clk,
    input  logic rst_n,
    input  logic boundary_i,
    input  logic sense_a_i,
    input  logic ie_i,
    output logic ie_kill_o,
    output logic take_o
);
    logic take_q;

    // Entry condition: boundary, request pending, interrupts enabled.
    always_comb begin
        ie_kill_o = boundary_i & sense_a_i & ie_i;
    end

    // Register the take pulse for the pointer file.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_q <= 1'b0;
        end else begin
            take_q <= ie_kill_o;
        end
    end

    assign take_o = take_q;
endmodule

// File: rtl/status_flags.sv
// Module: writable status bits (carry, overflow, enable, user flags).
// Assumes sense mirrors live elsewhere. Priority per bit: interrupt entry >
// disable > enable > accumulator copy for IE; strobed update > accumulator
// copy for carry and overflow; accumulator copy alone for the user flags.
module status_flags
    import status_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cy_we_i,
    input  logic              cy_i,
    input  logic              ov_we_i,
    input  logic              ov_i,
    input  logic              ie_set_i,
    input  logic              ie_clr_i,
    input  logic              ie_kill_i,
    input  logic              acc_we_i,
    input  logic              acc_cy_i,
    input  logic              acc_ov_i,
    input  logic              acc_ie_i,
    input  logic [FLAG_W-1:0] acc_f_i,
    output logic              cy_o,
    output logic              ov_o,
    output logic              ie_o,
    output logic [FLAG_W-1:0] f_o
);
    logic              cy_q, ov_q, ie_q;
    logic [FLAG_W-1:0] f_q;
    logic              cy_d, ov_d, ie_d;
    logic [FLAG_W-1:0] f_d;

    // Next-state selection by priority.
    always_comb begin
        cy_d = cy_q;
        ov_d = ov_q;
        ie_d = ie_q;
        f_d  = f_q;
        if (acc_we_i) begin
            cy_d = acc_cy_i;
            ov_d = acc_ov_i;
            ie_d = acc_ie_i;
            f_d  = acc_f_i;
        end
        if (cy_we_i)   cy_d = cy_i;
        if (ov_we_i)   ov_d = ov_i;
        if (ie_set_i)  ie_d = 1'b1;
        if (ie_clr_i)  ie_d = 1'b0;
        if (ie_kill_i) ie_d = 1'b0;
    end

    // State update with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cy_q <= 1'b0;
            ov_q <= 1'b0;
            ie_q <= 1'b0;
            f_q  <= '0;
        end else begin
            cy_q <= cy_d;
            ov_q <= ov_d;
            ie_q <= ie_d;
            f_q  <= f_d;
        end
    end

    assign cy_o = cy_q;
    assign ov_o = ov_q;
    assign ie_o = ie_q;
    assign f_o  = f_q;
endmodule

// File: rtl/status_irq_unit.sv
// Module: status byte and interrupt entry, top level.
// Assumes pins are asynchronous and all other inputs synchronous to clk.
// Ties the sense synchronizer, the writable bits and the entry sequencer together.
module status_irq_unit
    import status_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sense_a_i,
    input  logic              sense_b_i,
    input  logic              cy_we_i,
    input  logic              cy_i,
    input  logic              ov_we_i,
    input  logic              ov_i,
    input  logic              ie_set_i,
    input  logic              ie_clr_i,
    input  logic              acc_we_i,
    input  logic [STAT_W-1:0] acc_data_i,
    input  logic              boundary_i,
    output logic [FLAG_W-1:0] flag_o,
    output logic [STAT_W-1:0] status_o,
    output logic              irq_take_o
);
    logic [1:0]        sense_sync_w;
    logic              cy_w, ov_w, ie_w, kill_w;
    logic [FLAG_W-1:0] f_w;
    status_t           stat_w;
    logic              unused_acc_bits;

    // Sense bits mirror the pins and cannot be written.
    assign unused_acc_bits = ^acc_data_i[BIT_SB:BIT_SA];

    sense_sync #(.WIDTH(2), .STAGES(SYNC_N)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sense_b_i, sense_a_i}),
        .sync_o  (sense_sync_w)
    );

    irq_entry u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .boundary_i (boundary_i),
        .sense_a_i  (sense_sync_w[0]),
        .ie_i       (ie_w),
        .ie_kill_o  (kill_w),
        .take_o     (irq_take_o)
    );

    status_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .cy_we_i   (cy_we_i),
        .cy_i      (cy_i),
        .ov_we_i   (ov_we_i),
        .ov_i      (ov_i),
        .ie_set_i  (ie_set_i),
        .ie_clr_i  (ie_clr_i),
        .ie_kill_i (kill_w),
        .acc_we_i  (acc_we_i),
        .acc_cy_i  (acc_data_i[BIT_CY]),
        .acc_ov_i  (acc_data_i[BIT_OV]),
        .acc_ie_i  (acc_data_i[BIT_IE]),
        .acc_f_i   (acc_data_i[FLAG_W-1:0]),
        .cy_o      (cy_w),
        .ov_o      (ov_w),
        .ie_o      (ie_w),
        .f_o       (f_w)
    );

    // Assemble the status byte in its fixed layout.
    always_comb begin
        stat_w.cy = cy_w;
        stat_w.ov = ov_w;
        stat_w.sb = sense_sync_w[1];
        stat_w.sa = sense_sync_w[0];
        stat_w.ie = ie_w;
        stat_w.f  = f_w;
    end

    assign status_o = stat_w;
    assign flag_o   = f_w;
endmodule

// File: rtl/status_irq_checker.sv
// Module: property checker for status_irq_unit, attached by bind.
// Assumes synchronous active-low reset; a small counter gates checks that look back two edges.
module status_irq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sense_a_i,
    input logic       sense_b_i,
    input logic       ie_set_i,
    input logic       ie_clr_i,
    input logic       boundary_i,
    input logic [7:0] status_o,
    input logic       irq_take_o
);
    logic [1:0] age_q;

    // Count edges since reset, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)            age_q <= 2'd0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    AST_TAKE_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take_o |-> !status_o[3]); // R9
    AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take_o |-> $past(boundary_i)); // R10
    AST_TAKE_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take_o |-> $past(status_o[3])); // R11
    AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take_o |=> !irq_take_o); // R12
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ie_clr_i |=> !status_o[3]); // R5
    AST_SET_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_set_i && !ie_clr_i && !(boundary_i && status_o[4] && status_o[3])) |=> status_o[3]); // R5
    AST_SENSE_A_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (status_o[4] == $past(sense_a_i, 2))); // R3
    AST_SENSE_B_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (status_o[5] == $past(sense_b_i, 2))); // R3
endmodule

bind status_irq_unit status_irq_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sense_a_i  (sense_a_i),
    .sense_b_i  (sense_b_i),
    .ie_set_i   (ie_set_i),
    .ie_clr_i   (ie_clr_i),
    .boundary_i (boundary_i),
    .status_o   (status_o),
    .irq_take_o (irq_take_o)
);

// File: tb/test_status_irq_unit.sv
// Bench: behavioural reference model compared against the outputs on every clock.
module test_status_irq_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sense_a = 1'b0, sense_b = 1'b0;
    logic       cy_we = 1'b0, cy = 1'b0, ov_we = 1'b0, ov = 1'b0;
    logic       ie_set = 1'b0, ie_clr = 1'b0, acc_we = 1'b0, boundary = 1'b0;
    logic [7:0] acc = 8'h00;
    logic [2:0] flag_o;
    logic [7:0] status_o;
    logic       irq_take_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // Reference state
    bit m_cy, m_ov, m_ie, m_take;
    bit [2:0] m_f;
    bit m_sa[$];
    bit m_sb[$];

    always #10 clk = ~clk;

    status_irq_unit i_status_irq_unit (
        .clk(clk), .rst_n(rst_n), .sense_a_i(sense_a), .sense_b_i(sense_b),
        .cy_we_i(cy_we), .cy_i(cy), .ov_we_i(ov_we), .ov_i(ov),
        .ie_set_i(ie_set), .ie_clr_i(ie_clr), .acc_we_i(acc_we), .acc_data_i(acc),
        .boundary_i(boundary), .flag_o(flag_o), .status_o(status_o), .irq_take_o(irq_take_o)
    );

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic bit [7:0] m_status();
        return {m_cy, m_ov, m_sb[1], m_sa[1], m_ie, m_f};
    endfunction

    // Advance one clock: update the model from the held inputs, then compare.
    task automatic tick(string phase);
        bit nt;
        @(posedge clk);
        #1;
        if (!rst_n) begin
            m_cy = 0; m_ov = 0; m_ie = 0; m_f = 0; m_take = 0;
            m_sa = '{0, 0}; m_sb = '{0, 0};
        end else begin
            nt = boundary && m_sa[1] && m_ie;
            if (acc_we) begin
                m_cy = acc[7]; m_ov = acc[6]; m_ie = acc[3]; m_f = acc[2:0];
            end
            if (cy_we) m_cy = cy;
            if (ov_we) m_ov = ov;
            if (ie_set) m_ie = 1;
            if (ie_clr) m_ie = 0;
            if (nt) m_ie = 0;
            m_take = nt;
            void'(m_sa.pop_back()); m_sa.push_front(sense_a);
            void'(m_sb.pop_back()); m_sb.push_front(sense_b);
        end
        @(negedge clk);
        check({"R2 status byte / ", phase}, status_o, m_status());
        check({"R4 flag pins / ", phase}, flag_o, m_f);
        check({"R9 take pulse / ", phase}, irq_take_o, m_take);
    endtask

    task automatic idle();
        cy_we = 0; ov_we = 0; ie_set = 0; ie_clr = 0; acc_we = 0; boundary = 0;
    endtask

    initial begin
        m_sa = '{0, 0}; m_sb = '{0, 0};
        @(negedge clk);
        tick("R1 reset");
        tick("R1 reset");
        check("R1 reset status", status_o, 8'h00);
        check("R1 reset take", irq_take_o, 0);
        rst_n = 1;
        tick("run");

        // R5: set, clear, both together
        ie_set = 1; tick("R5 set"); idle();
        check("R5 ie set", status_o[3], 1);
        ie_clr = 1; tick("R5 clr"); idle();
        ie_set = 1; tick("R5 set"); ie_clr = 1; tick("R5 clr wins"); idle();
        check("R5 clear beats set", status_o[3], 0);

        // R6: accumulator copy, bits 5:4 ignored
        acc = 8'hFF; acc_we = 1; tick("R6 acc write"); idle();
        check("R6 acc copy, sense bits untouched", status_o, 8'hCF);
        // R7: carry/overflow strobes beat accumulator copy
        acc = 8'hC0; acc_we = 1; cy_we = 1; cy = 0; ov_we = 1; ov = 0;
        tick("R7 cy/ov priority"); idle();
        check("R7 cy/ov over acc", status_o[7:6], 2'b00);
        // R8: disable beats accumulator copy of IE=1
        acc = 8'h08; acc_we = 1; ie_clr = 1; tick("R8 ie cmd priority"); idle();
        check("R8 clr over acc", status_o[3], 0);

        // R3: sense edges appear two edges late
        sense_b = 1; tick("R3 sense b"); check("R3 not yet", status_o[5], 0);
        tick("R3 sense b"); check("R3 after two edges", status_o[5], 1);
        sense_b = 0;

        // R10: sense A high, enabled, no boundary
        ie_set = 1; sense_a = 1; tick("R10"); idle();
        for (int i = 0; i < 5; i++) begin
            tick("R10 no boundary");
            check("R10 no take without boundary", irq_take_o, 0);
        end
        // R9: take at boundary, together with ie_set and acc write
        boundary = 1; ie_set = 1; acc = 8'h08; acc_we = 1; tick("R9 take"); idle();
        check("R9 take fires", irq_take_o, 1);
        check("R9 ie cleared", status_o[3], 0);
        // R11/R12: next boundary with sense A still high, IE now 0
        boundary = 1; tick("R11 blocked"); idle();
        check("R12 single cycle", irq_take_o, 0);
        boundary = 1; tick("R11 blocked"); idle();
        check("R11 no nested take", irq_take_o, 0);
        sense_a = 0;

        // Mixed random traffic, model compared every clock
        for (int i = 0; i < 3000; i++) begin
            sense_a = ($urandom % 4) != 0;
            sense_b = $urandom;
            cy_we = ($urandom % 3) == 0; cy = $urandom;
            ov_we = ($urandom % 3) == 0; ov = $urandom;
            ie_set = ($urandom % 4) == 0; ie_clr = ($urandom % 8) == 0;
            acc_we = ($urandom % 5) == 0; acc = $urandom;
            boundary = ($urandom % 3) == 0;
            if (i % 500 == 250) rst_n = 0; else rst_n = 1;
            tick("random");
        end
        idle();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule